// File: doc/BRIEF.md
# Dual-Channel DDS Waveform Generator

This block produces two periodic waveforms from one shared sample table by direct digital synthesis. Each channel keeps its own phase accumulator. On every cycle in which `sample_en` is high, the accumulator of a running channel adds its programmed increment, wrapping modulo 2^PHASE_W. The top ADDR_W bits of the accumulator select a table entry. The output frequency is therefore increment × f_s / 2^PHASE_W, where f_s is the rate of `sample_en` pulses. When an accumulator wraps, the channel emits a one-cycle roll-over pulse.

Software drives one write-only register port. Through it, software fills the sample table, sets each channel's enable, trigger mode and increment, and turns on a synchronising mode. In that mode, channel B writes are parked in shadow registers and take effect on the same clock edge as the matching channel A write. Both outputs can then be retuned together, without stopping either channel. A channel can also be told to wait, after it is enabled, for a pulse on its trigger input before it starts.

Each channel is a three-state machine. CH_IDLE holds the accumulator and the output at zero. CH_ARMED waits for the trigger. CH_RUN advances the phase. The transitions are:
- CH_IDLE→CH_RUN when the channel is enabled with the trigger mode off.
- CH_IDLE→CH_ARMED when the channel is enabled with the trigger mode on.
- CH_ARMED→CH_RUN when the trigger input is high.
- CH_ARMED→CH_IDLE and CH_RUN→CH_IDLE when the enable is cleared.

Each state otherwise holds.

Top module: `dds_dual`

## Requirements
- R1: A write to address 0x8 stores `wr_data[SAMP_W-1:0]` into table entry `wr_data[16+ADDR_W-1:16]`. Both channels read this single table. A channel's output equals the entry addressed by its accumulator's top ADDR_W bits, one clock after that accumulator value is registered.
- R2: In CH_RUN, the accumulator adds the increment modulo 2^PHASE_W only on clock edges where `sample_en` is high. Otherwise it holds.
- R3: A roll-over output is high for exactly the one cycle after an edge on which its accumulator addition carried out of the top bit, and low otherwise.
- R4: Control register bit 0 is the enable. While a channel is not in CH_RUN, its accumulator is zero, and its sample output is zero from the following cycle. Clearing the enable returns the channel to CH_IDLE.
- R5: Control register bit 1 selects trigger mode. An enabled channel in this mode sits in CH_ARMED, outputting zero, until its trigger input is sampled high on a clock edge. From that edge it is in CH_RUN.
- R6: Rewriting an increment while a channel runs changes the step from the next advance onward. The accumulator is neither cleared nor paused.
- R7: Address 0x3 bit 0 is the sync flag. While it is set, writes to channel B's control (0x4) or increment (0x5) leave the active channel B value unchanged and are held pending.
- R8: A write to channel A's control (0x0) or increment (0x1) applies any pending channel B value of the same kind on the same clock edge as channel A's own update.
- R9: After reset, all outputs are zero and both channels are in CH_IDLE. With the sync flag clear, channel B writes take effect on the next edge. Channel A uses addresses 0x0 and 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | PHASE_W | Register write data |
| sample_en | input | 1 | Qualifies every accumulator advance |
| trig_a | input | 1 | Start trigger, channel A |
| trig_b | input | 1 | Start trigger, channel B |
| sample_a | output | SAMP_W | Channel A sample |
| sample_b | output | SAMP_W | Channel B sample |
| roll_a | output | 1 | Channel A phase wrap pulse |
| roll_b | output | 1 | Channel B phase wrap pulse |

## Verification
The channel A increment write can coincide with two other updates on the same edge: the commit of a pending channel B increment, and an advance of both accumulators, because `sample_en` stays high through the write. The bench provokes this in two steps. It first parks a channel B increment while the sync flag is set and checks that channel B keeps stepping at its old rate. It then writes channel A and checks, every cycle, both sample streams and both roll-over pulses against an arithmetic model in which both new increments first apply on the same advance. Live retunes are likewise issued while wraps are occurring, so that a roll-over pulse and an increment change share a cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic wait_trig;
        logic enable;
    } ch_ctrl_t;

    localparam logic [3:0] REG_A_CTRL = 4'h0;
    localparam logic [3:0] REG_A_INC  = 4'h1;
    localparam logic [3:0] REG_SYNC   = 4'h3;
    localparam logic [3:0] REG_B_CTRL = 4'h4;
    localparam logic [3:0] REG_B_INC  = 4'h5;
    localparam logic [3:0] REG_TABLE  = 4'h8;

    localparam int TBL_IDX_LSB = 16;

endpackage

// File: rtl/dds_wave_ram.sv
module dds_wave_ram #(
    parameter int ADDR_W = 6,
    parameter int SAMP_W = 12,
    parameter int PORTS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [SAMP_W-1:0]             wdata,
    input  logic [PORTS-1:0][ADDR_W-1:0]  raddr,
    output logic [PORTS-1:0][SAMP_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g] <= '0;
            end else begin
                rdata[g] <= mem[raddr[g]];
            end
        end
    end

endmodule

// File: rtl/dds_regs.sv
module dds_regs
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int SAMP_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [3:0]                   wr_addr,
    input  logic [PHASE_W-1:0]           wr_data,
    output ch_ctrl_t [1:0]               ctrl_o,
    output logic [1:0][PHASE_W-1:0]      inc_o,
    output logic                         sync_o,
    output logic                         pend_inc_o,
    output logic [PHASE_W-1:0]           shadow_inc_o,
    output logic                         tbl_we,
    output logic [ADDR_W-1:0]            tbl_waddr,
    output logic [SAMP_W-1:0]            tbl_wdata
);
    ch_ctrl_t               ctrl_q [2];
    logic [PHASE_W-1:0]     inc_q  [2];
    logic                   sync_q;
    ch_ctrl_t               shadow_ctrl_q;
    logic                   pend_ctrl_q;
    logic [PHASE_W-1:0]     shadow_inc_q;
    logic                   pend_inc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q[0]     <= '0;
            ctrl_q[1]     <= '0;
            inc_q[0]      <= '0;
            inc_q[1]      <= '0;
            sync_q        <= 1'b0;
            shadow_ctrl_q <= '0;
            pend_ctrl_q   <= 1'b0;
            shadow_inc_q  <= '0;
            pend_inc_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_A_CTRL: begin
                    ctrl_q[0] <= ch_ctrl_t'(wr_data[1:0]);
                    if (pend_ctrl_q) begin
                        ctrl_q[1]   <= shadow_ctrl_q;
                        pend_ctrl_q <= 1'b0;
                    end
                end
                REG_A_INC: begin
                    inc_q[0] <= wr_data;
                    if (pend_inc_q) begin
                        inc_q[1]   <= shadow_inc_q;
                        pend_inc_q <= 1'b0;
                    end
                end
                REG_SYNC: begin
                    sync_q <= wr_data[0];
                end
                REG_B_CTRL: begin
                    if (sync_q) begin
                        shadow_ctrl_q <= ch_ctrl_t'(wr_data[1:0]);
                        pend_ctrl_q   <= 1'b1;
                    end else begin
                        ctrl_q[1] <= ch_ctrl_t'(wr_data[1:0]);
                    end
                end
                REG_B_INC: begin
                    if (sync_q) begin
                        shadow_inc_q <= wr_data;
                        pend_inc_q   <= 1'b1;
                    end else begin
                        inc_q[1] <= wr_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            ctrl_o[c] = ctrl_q[c];
            inc_o[c]  = inc_q[c];
        end
    end

    assign sync_o       = sync_q;
    assign pend_inc_o   = pend_inc_q;
    assign shadow_inc_o = shadow_inc_q;
    assign tbl_we       = wr_en && (wr_addr == REG_TABLE);
    assign tbl_waddr    = wr_data[TBL_IDX_LSB +: ADDR_W];
    assign tbl_wdata    = wr_data[SAMP_W-1:0];

endmodule

// File: rtl/dds_channel.sv
module dds_channel
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int SAMP_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ch_ctrl_t             ctrl,
    input  logic [PHASE_W-1:0]   inc,
    input  logic                 sample_en,
    input  logic                 trig,
    input  logic [SAMP_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [SAMP_W-1:0]    sample,
    output logic                 roll,
    output ch_state_e            state_o,
    output logic [PHASE_W-1:0]   acc_o
);
    ch_state_e            state_q, state_d;
    logic [PHASE_W-1:0]   acc_q;
    logic                 roll_q;
    logic                 run_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctrl.enable) begin
                    state_d = ctrl.wait_trig ? CH_ARMED : CH_RUN;
                end
            end
            CH_ARMED: begin
                if (!ctrl.enable) begin
                    state_d = CH_IDLE;
                end else if (trig) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (!ctrl.enable) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs: accumulator, wrap pulse, output gating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            roll_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            run_q <= (state_q == CH_RUN);
            if (state_q != CH_RUN) begin
                acc_q  <= '0;
                roll_q <= 1'b0;
            end else if (sample_en) begin
                {roll_q, acc_q} <= {1'b0, acc_q} + {1'b0, inc};
            end else begin
                roll_q <= 1'b0;
            end
        end
    end

    assign rd_addr = acc_q[PHASE_W-1 -: ADDR_W];
    assign sample  = run_q ? rd_data : '0;
    assign roll    = roll_q;
    assign state_o = state_q;
    assign acc_o   = acc_q;

endmodule

// File: rtl/dds_dual.sv
module dds_dual
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int SAMP_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [PHASE_W-1:0]   wr_data,
    input  logic                 sample_en,
    input  logic                 trig_a,
    input  logic                 trig_b,
    output logic [SAMP_W-1:0]    sample_a,
    output logic [SAMP_W-1:0]    sample_b,
    output logic                 roll_a,
    output logic                 roll_b
);
    localparam int NCH = 2;

    ch_ctrl_t [NCH-1:0]               ch_ctrl;
    logic [NCH-1:0][PHASE_W-1:0]      ch_inc;
    logic                             sync_on;
    logic                             pend_inc_b;
    logic [PHASE_W-1:0]               shadow_inc_b;
    logic                             tbl_we;
    logic [ADDR_W-1:0]                tbl_waddr;
    logic [SAMP_W-1:0]                tbl_wdata;
    logic [NCH-1:0][ADDR_W-1:0]       rd_addr;
    logic [NCH-1:0][SAMP_W-1:0]       rd_data;
    logic [NCH-1:0][SAMP_W-1:0]       samp_v;
    logic [NCH-1:0]                   roll_v;
    logic [NCH-1:0]                   trig_v;
    ch_state_e                        ch_state [NCH];
    logic [PHASE_W-1:0]               ch_acc   [NCH];

    assign trig_v = {trig_b, trig_a};

    dds_regs #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl_o       (ch_ctrl),
        .inc_o        (ch_inc),
        .sync_o       (sync_on),
        .pend_inc_o   (pend_inc_b),
        .shadow_inc_o (shadow_inc_b),
        .tbl_we       (tbl_we),
        .tbl_waddr    (tbl_waddr),
        .tbl_wdata    (tbl_wdata)
    );

    dds_wave_ram #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .PORTS(NCH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dds_channel #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ch_ctrl[g]),
            .inc       (ch_inc[g]),
            .sample_en (sample_en),
            .trig      (trig_v[g]),
            .rd_data   (rd_data[g]),
            .rd_addr   (rd_addr[g]),
            .sample    (samp_v[g]),
            .roll      (roll_v[g]),
            .state_o   (ch_state[g]),
            .acc_o     (ch_acc[g])
        );
    end

    assign sample_a = samp_v[0];
    assign sample_b = samp_v[1];
    assign roll_a   = roll_v[0];
    assign roll_b   = roll_v[1];

endmodule

// File: rtl/dds_dual_chk.sv
module dds_dual_chk
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int SAMP_W  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [3:0]          wr_addr,
    input logic [PHASE_W-1:0]  wr_data,
    input logic                sample_en,
    input logic                trig_b,
    input logic [SAMP_W-1:0]   sample_a,
    input logic [SAMP_W-1:0]   sample_b,
    input logic                roll_a,
    input logic                roll_b,
    input ch_state_e           state_a,
    input ch_state_e           state_b,
    input logic [PHASE_W-1:0]  acc_a,
    input logic [PHASE_W-1:0]  acc_b,
    input ch_ctrl_t            ctrl_b,
    input logic [PHASE_W-1:0]  inc_b,
    input logic                sync,
    input logic                pend_inc_b,
    input logic [PHASE_W-1:0]  shadow_inc_b
);
    AST_A_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_a != CH_RUN) |=> (sample_a == '0)); // R4
    AST_B_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_b != CH_RUN) |=> (sample_b == '0)); // R4
    AST_A_HOLD_NO_SE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_a == CH_RUN && !sample_en) |=> (acc_a == $past(acc_a) || acc_a == '0)); // R2
    AST_A_ROLL_NEEDS_SE: assert property (@(posedge clk) disable iff (!rst_n)
        roll_a |-> $past(sample_en)); // R3
    AST_A_ROLL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        roll_a |-> (acc_a < $past(acc_a))); // R3
    AST_B_ROLL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        roll_b |-> (acc_b < $past(acc_b))); // R3
    AST_B_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_b == CH_ARMED && ctrl_b.enable && !trig_b) |=> (state_b == CH_ARMED)); // R5
    AST_SYNC_HOLDS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && wr_en && wr_addr == REG_B_INC) |=> $stable(inc_b)); // R7
    AST_A_COMMITS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_A_INC && pend_inc_b) |=> (inc_b == $past(shadow_inc_b))); // R8
    AST_B_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && wr_en && wr_addr == REG_B_INC) |=> (inc_b == $past(wr_data))); // R9
endmodule

bind dds_dual dds_dual_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .sample_en    (sample_en),
    .trig_b       (trig_b),
    .sample_a     (sample_a),
    .sample_b     (sample_b),
    .roll_a       (roll_a),
    .roll_b       (roll_b),
    .state_a      (ch_state[0]),
    .state_b      (ch_state[1]),
    .acc_a        (ch_acc[0]),
    .acc_b        (ch_acc[1]),
    .ctrl_b       (ch_ctrl[1]),
    .inc_b        (ch_inc[1]),
    .sync         (sync_on),
    .pend_inc_b   (pend_inc_b),
    .shadow_inc_b (shadow_inc_b)
);

// File: tb/tb_dds_dual.sv
`timescale 1ns/1ps
module tb_dds_dual;
    localparam int PW = 32;
    localparam int AW = 6;
    localparam int SW = 12;
    localparam int TD = 1 << AW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, wr_en, sample_en, trig_a, trig_b;
    logic [3:0]    wr_addr;
    logic [PW-1:0] wr_data;
    logic [SW-1:0] sample_a, sample_b;
    logic          roll_a, roll_b;

    dds_dual #(.PHASE_W(PW), .ADDR_W(AW), .SAMP_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_en(sample_en), .trig_a(trig_a), .trig_b(trig_b),
        .sample_a(sample_a), .sample_b(sample_b), .roll_a(roll_a), .roll_b(roll_b)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R9";
    bit    done = 0;

    // Behavioural model built from the requirements
    logic [PW-1:0] m_acc [2], m_inc [2], n_acc [2];
    logic [1:0]    m_ctrl [2];
    int            m_state [2], n_state [2];
    logic          m_roll [2], n_roll [2], m_runq [2], n_runq [2], tr [2];
    logic [SW-1:0] m_rd [2], n_rd [2];
    logic [SW-1:0] m_mem [TD];
    logic          m_sync, m_pc, m_pi;
    logic [1:0]    m_sc;
    logic [PW-1:0] m_si;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_acc[c] = '0; m_inc[c] = '0; m_ctrl[c] = '0; m_state[c] = 0;
                m_roll[c] = 0; m_runq[c] = 0; m_rd[c] = '0;
            end
            m_sync = 0; m_pc = 0; m_pi = 0; m_sc = '0; m_si = '0;
        end else begin
            tr[0] = trig_a; tr[1] = trig_b;
            for (int c = 0; c < 2; c++) begin
                n_rd[c]   = m_mem[m_acc[c][PW-1 -: AW]];
                n_runq[c] = (m_state[c] == 2);
                if (!m_ctrl[c][0])        n_state[c] = 0;
                else if (m_state[c] == 0) n_state[c] = m_ctrl[c][1] ? 1 : 2;
                else if (m_state[c] == 1) n_state[c] = tr[c] ? 2 : 1;
                else                      n_state[c] = 2;
                if (m_state[c] != 2) begin
                    n_acc[c] = '0; n_roll[c] = 0;
                end else if (sample_en) begin
                    {n_roll[c], n_acc[c]} = {1'b0, m_acc[c]} + {1'b0, m_inc[c]};
                end else begin
                    n_acc[c] = m_acc[c]; n_roll[c] = 0;
                end
            end
            for (int c = 0; c < 2; c++) begin
                m_rd[c] = n_rd[c]; m_runq[c] = n_runq[c]; m_state[c] = n_state[c];
                m_acc[c] = n_acc[c]; m_roll[c] = n_roll[c];
            end
            if (wr_en) begin
                case (wr_addr)
                    4'h0: begin m_ctrl[0] = wr_data[1:0]; if (m_pc) begin m_ctrl[1] = m_sc; m_pc = 0; end end
                    4'h1: begin m_inc[0] = wr_data; if (m_pi) begin m_inc[1] = m_si; m_pi = 0; end end
                    4'h3: m_sync = wr_data[0];
                    4'h4: if (m_sync) begin m_sc = wr_data[1:0]; m_pc = 1; end else m_ctrl[1] = wr_data[1:0];
                    4'h5: if (m_sync) begin m_si = wr_data; m_pi = 1; end else m_inc[1] = wr_data;
                    4'h8: m_mem[wr_data[16 +: AW]] = wr_data[SW-1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("sample_a", int'(sample_a), m_runq[0] ? int'(m_rd[0]) : 0);
            chk("sample_b", int'(sample_b), m_runq[1] ? int'(m_rd[1]) : 0);
            chk("roll_a", int'(roll_a), int'(m_roll[0]));
            chk("roll_b", int'(roll_b), int'(m_roll[1]));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [PW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input int div);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            sample_en = (j % div) == 0;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired (%s) actual=hung expected=done", tag);
        done = 1;
        summary();
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
        sample_en = 0; trig_a = 0; trig_b = 0;
        repeat (3) @(negedge clk);
        tag = "R9";
        chk("reset sample_a", int'(sample_a), 0);
        chk("reset sample_b", int'(sample_b), 0);
        chk("reset roll_a", int'(roll_a), 0);
        chk("reset roll_b", int'(roll_b), 0);
        rst_n = 1;

        tag = "R1";
        for (int i = 0; i < TD; i++) wr(4'h8, (i << 16) | ((i * 173 + 29) & 12'hFFF));
        wr(4'h1, 32'h0400_0000);
        wr(4'h0, 32'h1);
        sample_en = 1;
        run(150, 1);

        tag = "R2";
        for (int k = 2; k <= 4; k++) run(90, k);
        for (int k = 20; k < 32; k++) begin
            wr(4'h1, 32'h1 << k);
            run(70, (k % 2) + 1);
        end

        tag = "R3";
        wr(4'h1, 32'h0A30_0000);
        run(120, 1);
        wr(4'h1, 32'hFFFF_0000);
        run(40, 1);

        tag = "R6";
        wr(4'h1, 32'h0000_0001);
        run(30, 1);
        wr(4'h1, 32'h8000_0000);
        run(30, 1);
        wr(4'h1, 32'h0111_1111);
        run(80, 1);

        tag = "R5";
        wr(4'h5, 32'h0300_0000);
        wr(4'h4, 32'h3);
        run(30, 1);
        @(negedge clk); trig_b = 1;
        @(negedge clk); trig_b = 0;
        run(100, 1);

        tag = "R7";
        wr(4'h3, 32'h1);
        wr(4'h5, 32'h0555_0000);
        run(60, 1);
        wr(4'h4, 32'h0);
        run(40, 1);

        tag = "R8";
        wr(4'h1, 32'h0222_0000);
        run(60, 1);
        wr(4'h0, 32'h1);
        run(40, 1);

        tag = "R4";
        wr(4'h0, 32'h0);
        run(40, 1);
        wr(4'h0, 32'h1);
        run(40, 2);

        tag = "R9";
        wr(4'h3, 32'h0);
        wr(4'h4, 32'h1);
        wr(4'h5, 32'h0100_0000);
        run(80, 1);

        done = 1;
        summary();
    end

endmodule